// File: doc/BRIEF.md
# Two-Wire Slave Configuration Register Bank

This block lets a host on a two-wire serial bus (I2C signalling: SCL clock, SDA open-drain data) read and write a bank of 8-bit configuration registers. The block oversamples both lines on its own system clock, recognises start and stop conditions, and compares the first byte of each transfer against its 7-bit device address. On a write, the next byte sets an internal register pointer that the host cannot read. Every following data byte lands at that pointer, and the pointer then steps forward by one. A read first sets the pointer with a write, then issues a repeated start and the address with the read bit set. The slave then returns bytes most significant bit first and steps the pointer after each byte the master acknowledges.

Four adjacent registers together form one 32-bit frequency word. Bytes written to these registers wait in a shadow buffer. The whole word reaches the outputs in one clock, and only when all four bytes arrive in a single auto-increment burst that begins at the lowest of the four. The block withholds its acknowledge for an invalid pointer and for a write past the top register, and it repeats the top register on a read past the end. Every register value is presented on a parallel output bus.

The bus carries no flow control. The host paces every bit with SCL, so no valid/ready handshake exists and the slave never holds SCL low. SDA is modelled as a pull-down enable, and the pad outside the block turns it into an open-drain driver.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset every register reads zero on `regs_o` and `sda_pd` is low (SDA released).
- R2: A first byte whose upper seven bits equal `DEV_ADDR` is acknowledged (SDA held low during the ninth clock). Bit 0 of that byte selects write (0) or read (1). A byte with any other address is not acknowledged, and the transfer has no effect.
- R3: A pointer byte whose binary value is below `NREG` is acknowledged. A pointer byte of `NREG` or above is not acknowledged, the slave goes idle, and data bytes that follow are ignored.
- R4: On a write, each data byte is stored at the current pointer and acknowledged, and the pointer then advances by one.
- R5: On a read, the byte at the pointer is shifted out MSB first. After each master acknowledge the pointer advances and the next register is sent. A master no-acknowledge ends the read.
- R6: A read that runs past register `NREG-1` keeps returning the contents of register `NREG-1`.
- R7: A write byte aimed past register `NREG-1` is not stored anywhere and is not acknowledged, and the slave returns to idle.
- R8: Registers `GBASE` to `GBASE+3` change together in one clock. This happens only after the fourth of four bytes written in order, starting at `GBASE`, within one transaction. Before that fourth byte the outputs keep their old values.
- R9: A burst that starts inside the group above `GBASE`, or that ends before its fourth byte, leaves all four group outputs unchanged.
- R10: A start or stop condition anywhere in a byte abandons that byte without storing it. A start returns the slave to address reception, and a stop returns it to idle.
- R11: The slave changes `sda_pd` only while SCL is low, except when it releases SDA on a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pd | output | 1 | 1 = pull SDA low, 0 = release |
| regs_o | output | NREG*8 | All register values, register i at bits [8i+7:8i] |

## Verification
The bench builds the block with `NREG = 12`, `GBASE = 4` and `DEV_ADDR = 7'h2A`. With these values the top register, 11, can be reached in a short burst, so read overrun and write overrun can each be driven with a handful of bytes, and pointer 12 serves as the first invalid value. Registers 4 to 7 hold the frequency group, with plain registers on both sides of it. The same burst paths therefore exercise group commit, partial group writes and out-of-order group writes next to ordinary writes.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_MACK
  } bus_st_e;

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  localparam int NLINE = 2;

  logic [NLINE-1:0] raw;
  logic [NLINE-1:0] cur;
  logic [NLINE-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain   <= '1;
        prev[l] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[l]};
        prev[l] <= chain[STAGES-1];
      end
    end
    assign cur[l] = chain[STAGES-1];
  end

  assign scl_q    = cur[0];
  assign sda_q    = cur[1];
  assign scl_rise = cur[0] & ~prev[0];
  assign scl_fall = ~cur[0] & prev[0];
  assign start_c  = cur[0] & prev[0] & prev[1] & ~cur[1];
  assign stop_c   = cur[0] & prev[0] & ~prev[1] & cur[1];

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NREG     = 46
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_q,
  input  logic       start_c,
  input  logic       stop_c,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       txn_clr,
  output logic       sda_pd
);

  localparam logic [7:0] TOP   = 8'(NREG - 1);
  localparam logic [7:0] LIMIT = 8'(NREG);

  bus_st_e    st_q, after_q;
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic [7:0] ptr_q;
  logic       mack_q;
  logic       byte_done;

  assign byte_done = scl_fall && (cnt_q == 4'd8);
  assign txn_clr   = start_c | stop_c;
  assign rd_addr   = (ptr_q >= LIMIT) ? TOP : ptr_q;
  assign wr_addr   = ptr_q;
  assign wr_data   = sh_q;
  assign wr_en     = !txn_clr && (st_q == ST_WDATA) && byte_done && (ptr_q < LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      after_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      mack_q  <= 1'b0;
      sda_pd  <= 1'b0;
    end else if (start_c) begin
      st_q   <= ST_ADDR;
      cnt_q  <= '0;
      sda_pd <= 1'b0;
    end else if (stop_c) begin
      st_q   <= ST_IDLE;
      sda_pd <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_q};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            st_q <= ST_IDLE;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                sda_pd  <= 1'b1;
                st_q    <= ST_ACK;
                after_q <= sh_q[0] ? ST_RDATA : ST_PTR;
              end
            end else if (st_q == ST_PTR) begin
              if (sh_q < LIMIT) begin
                ptr_q   <= sh_q;
                sda_pd  <= 1'b1;
                st_q    <= ST_ACK;
                after_q <= ST_WDATA;
              end
            end else if (ptr_q < LIMIT) begin
              ptr_q   <= ptr_q + 8'd1;
              sda_pd  <= 1'b1;
              st_q    <= ST_ACK;
              after_q <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            st_q  <= after_q;
            if (after_q == ST_RDATA) begin
              sh_q   <= rd_data;
              sda_pd <= ~rd_data[7];
            end else begin
              sda_pd <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              sda_pd <= 1'b0;
              cnt_q  <= '0;
              st_q   <= ST_MACK;
              ptr_q  <= (ptr_q >= TOP) ? TOP : ptr_q + 8'd1;
            end else begin
              sh_q   <= {sh_q[6:0], 1'b0};
              sda_pd <= ~sh_q[6];
              cnt_q  <= cnt_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_q;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_q   <= rd_data;
              sda_pd <= ~rd_data[7];
              cnt_q  <= '0;
              st_q   <= ST_RDATA;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank #(
  parameter int NREG  = 46,
  parameter int GBASE = 4,
  parameter int GLEN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              txn_clr,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_o
);

  localparam int         GW    = $clog2(GLEN + 1);
  localparam logic [7:0] G_LO  = 8'(GBASE);
  localparam logic [7:0] G_END = 8'(GBASE + GLEN);

  logic [7:0]    bank [NREG];
  logic [7:0]    shadow [GLEN];
  logic [GW-1:0] gcnt_q;
  logic          in_grp;
  logic [7:0]    gidx;
  logic          commit;

  assign in_grp = (wr_addr >= G_LO) && (wr_addr < G_END);
  assign gidx   = wr_addr - G_LO;
  assign commit = wr_en && in_grp && (gidx == 8'(GLEN - 1)) && (gcnt_q == GW'(GLEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || txn_clr) begin
      gcnt_q <= '0;
    end else if (wr_en && in_grp) begin
      if (gidx == 8'(gcnt_q)) begin
        shadow[gidx[GW-1:0]] <= wr_data;
        gcnt_q               <= commit ? '0 : gcnt_q + GW'(1);
      end else begin
        gcnt_q <= '0;
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] IDX = 8'(i);
    if (i >= GBASE && i < GBASE + GLEN) begin : g_grp
      always_ff @(posedge clk) begin
        if (!rst_n)
          bank[i] <= '0;
        else if (commit)
          bank[i] <= (i == GBASE + GLEN - 1) ? wr_data : shadow[i - GBASE];
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)
          bank[i] <= '0;
        else if (wr_en && wr_addr == IDX)
          bank[i] <= wr_data;
      end
    end
    assign regs_o[i*8 +: 8] = bank[i];
  end

  assign rd_data = bank[rd_addr];

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NREG     = 46,
  parameter int         GBASE    = 4,
  parameter int         GLEN     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pd,
  output logic [NREG*8-1:0] regs_o
);

  logic       scl_q, sda_q, scl_rise, scl_fall, start_c, stop_c;
  logic       wr_en, txn_clr;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  cfg_i2c_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_q    (scl_q),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  cfg_i2c_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_q    (sda_q),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .txn_clr  (txn_clr),
    .sda_pd   (sda_pd)
  );

  cfg_i2c_regbank #(.NREG(NREG), .GBASE(GBASE), .GLEN(GLEN)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .txn_clr (txn_clr),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int NREG  = 46,
  parameter int GBASE = 4,
  parameter int GLEN  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_q,
  input logic              start_c,
  input logic              stop_c,
  input logic              sda_pd,
  input logic              wr_en,
  input logic [7:0]        wr_addr,
  input logic [NREG*8-1:0] regs_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (regs_o == '0 && !sda_pd));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < 8'(NREG)));

  // R8
  group_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o[GBASE*8 +: GLEN*8]) |->
      $past(wr_en && wr_addr == 8'(GBASE + GLEN - 1)));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_pd);

  // R11
  sda_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pd) |-> (!scl_q || $past(start_c || stop_c)));

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NREG(NREG), .GBASE(GBASE), .GLEN(GLEN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_q   (scl_q),
  .start_c (start_c),
  .stop_c  (stop_c),
  .sda_pd  (sda_pd),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .regs_o  (regs_o)
);

// File: tb/cfg_i2c_slave_tb.sv
`timescale 1ns/1ps
module cfg_i2c_slave_tb;

  localparam int         NR  = 12;
  localparam int         GB  = 4;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int         Q   = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            scl = 1'b1;
  logic            m_sda = 1'b1;
  logic            sda_pd;
  logic [NR*8-1:0] regs_o;
  wire             sda_bus = m_sda & ~sda_pd;

  int checks = 0;
  int errors = 0;
  int oe_bad = 0;
  int oe_moves = 0;
  bit finished = 0;

  logic [7:0] exp_r [NR];
  logic [7:0] wbuf [16];
  logic       wack [16];
  logic [7:0] rbuf [16];

  always #2.5 clk = ~clk;

  cfg_i2c_slave #(.DEV_ADDR(DEV), .NREG(NR), .GBASE(GB), .GLEN(4)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_bus),
    .sda_pd (sda_pd),
    .regs_o (regs_o)
  );

  // R11 monitor: the slave may move SDA only while SCL is low
  always @(sda_pd) begin
    if (rst_n === 1'b1) begin
      oe_moves++;
      if (scl === 1'b1) oe_bad++;
    end
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic b_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic b_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~mack);
  endtask

  function automatic logic [7:0] reg_at(input int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic cmp_all(input string req);
    for (int i = 0; i < NR; i++) check(req, reg_at(i), exp_r[i]);
  endtask

  // Address + pointer + n bytes from wbuf; acks in wack; returns address/pointer ack
  task automatic do_write(input logic [7:0] ptr, input int n, output logic a_ack, output logic p_ack);
    b_start();
    wr_byte({DEV, 1'b0}, a_ack);
    wr_byte(ptr, p_ack);
    for (int i = 0; i < n; i++) wr_byte(wbuf[i], wack[i]);
    b_stop();
  endtask

  task automatic do_read(input logic [7:0] ptr, input int n);
    logic a;
    b_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(ptr, a);
    b_start();
    wr_byte({DEV, 1'b1}, a);
    check("R5 read address ack", a, 1'b1);
    for (int i = 0; i < n; i++) rd_byte(rbuf[i], i != n - 1);
    b_stop();
  endtask

  task automatic t_reset();
    check("R1 sda released", sda_pd, 1'b0);
    cmp_all("R1 reset value");
  endtask

  task automatic t_addr();
    logic a;
    b_start();
    wr_byte({7'h15, 1'b0}, a);
    check("R2 foreign address nack", a, 1'b0);
    wr_byte(8'h00, a);
    wr_byte(8'hEE, a);
    b_stop();
    cmp_all("R2 foreign address no effect");
  endtask

  task automatic t_write_burst();
    logic a, p;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    do_write(8'h00, 3, a, p);
    check("R2 own address ack", a, 1'b1);
    check("R3 valid pointer ack", p, 1'b1);
    for (int i = 0; i < 3; i++) check("R4 data ack", wack[i], 1'b1);
    exp_r[0] = 8'hA1; exp_r[1] = 8'hB2; exp_r[2] = 8'hC3;
    cmp_all("R4 burst store");
  endtask

  task automatic t_bad_ptr();
    logic a, p;
    wbuf[0] = 8'h55;
    do_write(8'(NR), 1, a, p);
    check("R3 invalid pointer nack", p, 1'b0);
    check("R3 data after invalid pointer nack", wack[0], 1'b0);
    cmp_all("R3 invalid pointer no store");
    wbuf[0] = 8'h3C;
    do_write(8'(NR - 1), 1, a, p);
    check("R3 top pointer ack", p, 1'b1);
    exp_r[NR-1] = 8'h3C;
    cmp_all("R3 top pointer store");
  endtask

  task automatic t_read();
    do_read(8'h01, 2);
    check("R5 first read byte", rbuf[0], 8'hB2);
    check("R5 incremented read byte", rbuf[1], 8'hC3);
    check("R5 released after nack", sda_pd, 1'b0);
  endtask

  task automatic t_read_over();
    logic a, p;
    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
    do_write(8'(NR - 2), 2, a, p);
    exp_r[NR-2] = 8'h5A; exp_r[NR-1] = 8'h6B;
    do_read(8'(NR - 2), 4);
    check("R6 byte 0", rbuf[0], 8'h5A);
    check("R6 byte 1", rbuf[1], 8'h6B);
    check("R6 repeat top", rbuf[2], 8'h6B);
    check("R6 repeat top again", rbuf[3], 8'h6B);
  endtask

  task automatic t_write_over();
    logic a, p;
    wbuf[0] = 8'h77; wbuf[1] = 8'h88; wbuf[2] = 8'h99;
    do_write(8'(NR - 1), 3, a, p);
    check("R7 last valid ack", wack[0], 1'b1);
    check("R7 overrun nack", wack[1], 1'b0);
    check("R7 idle after overrun", wack[2], 1'b0);
    exp_r[NR-1] = 8'h77;
    cmp_all("R7 overrun not stored");
  endtask

  task automatic t_group_ok();
    logic a, p;
    b_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'(GB), p);
    wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a);
    check("R8 group held before fourth byte", regs_o[GB*8 +: 32], 32'h0);
    wr_byte(8'h44, a);
    check("R8 fourth byte ack", a, 1'b1);
    b_stop();
    check("R8 group committed", regs_o[GB*8 +: 32], 32'h44332211);
    exp_r[GB] = 8'h11; exp_r[GB+1] = 8'h22; exp_r[GB+2] = 8'h33; exp_r[GB+3] = 8'h44;
    cmp_all("R8 neighbours intact");
  endtask

  task automatic t_group_bad();
    logic a, p;
    wbuf[0] = 8'h99; wbuf[1] = 8'hAA; wbuf[2] = 8'hBB;
    do_write(8'(GB + 1), 3, a, p);
    check("R9 out-of-order group unchanged", regs_o[GB*8 +: 32], 32'h44332211);
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    do_write(8'(GB), 2, a, p);
    check("R9 partial group unchanged", regs_o[GB*8 +: 32], 32'h44332211);
    wbuf[0] = 8'h03; wbuf[1] = 8'h04;
    do_write(8'(GB + 2), 2, a, p);
    check("R9 shadow cleared by stop", regs_o[GB*8 +: 32], 32'h44332211);
    cmp_all("R9 bank unchanged");
  endtask

  task automatic t_abort();
    logic a;
    b_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h02, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    b_stop();
    cmp_all("R10 stop mid-byte no store");
    b_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h02, a);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    b_start();
    wr_byte({DEV, 1'b1}, a);
    check("R10 start mid-byte back to address", a, 1'b1);
    rd_byte(rbuf[0], 1'b0);
    b_stop();
    check("R10 reg intact after abort", rbuf[0], 8'hC3);
    cmp_all("R10 bank after abort");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NR; i++) exp_r[i] = 8'h00;
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_addr();
    t_write_burst();
    t_bad_ptr();
    t_read();
    t_read_over();
    t_write_over();
    t_group_ok();
    t_group_bad();
    t_abort();
    check("R11 sda moves only with scl low", oe_bad, 0);
    check("R11 slave drove sda", oe_moves > 0, 1'b1);
    finish_run();
  end

endmodule